// File: doc/BRIEF.md
# Instruction Operand Decoder

This block takes one 16-bit instruction word and turns it into what an execution stage needs: the operation code, a special-operation selector when the operation code is zero, and a location for each of the two operands. A location is a register select, a memory address or a literal value. Some operand codes need an extra word that follows the instruction. The block reads those words itself through a one-cycle-latency memory read port, advances the program counter past them, and counts one extra cycle for each word it reads.

The block also works out the stack pointer that results from the operands. A stack operand in the source field pops and one in the destination field pushes. A subroutine call predecrements the stack pointer to make room for the return address. The source field is always resolved first, so the destination sees the stack pointer as the source operand left it. A skip input marks an instruction that is being stepped over: its extra words are still consumed, but its stack pointer change is dropped. The block does not execute the operation and does not contain the memory.

Top module: `operand_decoder`

## Requirements
- R1: The instruction word splits into an operation code in bits 4:0, a destination field in bits 9:5 and a source field in bits 15:10. `opcode_o` shows bits 4:0, and `special_o` is 1 exactly when the operation code is 0.
- R2: Location kinds are encoded as 0 = register, 1 = memory, 2 = literal and 3 = none. Codes 0x00–0x07 select general register 0–7 with kind 0. Codes 0x1b, 0x1c and 0x1d select 8 (stack pointer), 9 (program counter) and 10 (overflow register) with kind 0. Codes 0x08–0x0f give kind 1 at the address held in general register (code − 8).
- R3: Codes 0x10–0x17, 0x1a, 0x1e and 0x1f each read one extra word at the current program counter, and the program counter then advances by one. 0x10–0x17 give memory at (register + word), 0x1a gives memory at (stack pointer + word), 0x1e gives memory at (word), and 0x1f gives a literal equal to the word. `word_cycles_o` counts the words read.
- R4: Source-field codes 0x20–0x3f give a literal of (code − 0x21) modulo 2^16, which covers 0xFFFF for 0x20 through 30 for 0x3f.
- R5: Code 0x18 in the source field gives memory at the stack pointer and then increments it. In the destination field it decrements the stack pointer and gives memory at the new value. Code 0x19 gives memory at the stack pointer and leaves it unchanged. Arithmetic wraps modulo 2^16.
- R6: The source operand is resolved before the destination operand. Its extra word is read first, at the lower address, and the destination sees the stack pointer after the source's stack effect.
- R7: When the operation code is 0, the destination field is a special code and is not fetched or decoded as an operand. `spec_code_o` shows it. Codes 0–8 are idle, call, halt, raise interrupt, read interrupt address, set interrupt address, device count, device query and device signal, with `spec_known_o` = 1. Any other code gives `spec_known_o` = 0. For all specials other than call, the destination kind is 3.
- R8: `spec_cost_o` gives the cycle cost of the special code: 1, 3, 1, 4, 1, 1, 2, 4, 4 for codes 0–8. It is 0 for unknown codes and for non-special instructions.
- R9: For the call special (code 1), the stack pointer is decremented after the source operand's stack effect. The destination becomes memory at that new stack pointer, which is the slot for the return address.
- R10: `b_wr_o` is 0 when the destination is a literal (code 0x1f) or none, and 1 otherwise, so a write to a literal has no effect.
- R11: When `skip_i` is 1 at start, `sp_o` equals the stack pointer given at start. The program counter still advances past all extra words.
- R12: `done_o` is a one-cycle pulse that comes 1 + 2·N cycles after the start edge, where N is the number of extra words. Each word read raises `mem_rd_o` for one cycle, and the data is taken on the next cycle.
- R13: After reset, `busy_o`, `done_o` and `mem_rd_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin decoding `instr_i` (taken when idle) |
| instr_i | input | 16 | Instruction word |
| skip_i | input | 1 | Instruction is being skipped; drop its stack change |
| pc_i | input | 16 | Address of the word after the instruction |
| sp_i | input | 16 | Stack pointer at start |
| gpr_i | input | 128 | Eight general registers, register k in bits 16k+15:16k; held stable while busy |
| mem_rd_o | output | 1 | Read request for an extra word |
| mem_addr_o | output | 16 | Read address |
| mem_data_i | input | 16 | Read data, valid the cycle after the request |
| busy_o | output | 1 | Decode in progress |
| done_o | output | 1 | Results valid this cycle |
| opcode_o | output | 5 | Operation code |
| special_o | output | 1 | Operation code is 0 |
| spec_code_o | output | 5 | Special code (destination field) |
| spec_known_o | output | 1 | Special code is defined |
| spec_cost_o | output | 3 | Cycle cost of the special code |
| a_kind_o | output | 2 | Source location kind |
| a_sel_o | output | 4 | Source register select |
| a_val_o | output | 16 | Source address or literal |
| b_kind_o | output | 2 | Destination location kind |
| b_sel_o | output | 4 | Destination register select |
| b_val_o | output | 16 | Destination address or literal |
| b_wr_o | output | 1 | Destination is writable |
| sp_o | output | 16 | Resulting stack pointer |
| pc_o | output | 16 | Program counter after extra words |
| word_cycles_o | output | 2 | Extra words read (extra cycles) |

## Verification
Most internal faults show up in the single done cycle. If the word counter or the sequencer state is wrong, the pulse lands at the wrong cycle or `pc_o` is off by a word. If the resolution order is wrong, the two next-word values come out swapped, or a destination stack operand is offset by one from the source's pop. A wrong skip or call flag shows only in `sp_o` and the destination location of that same instruction. Stack cases are therefore checked in pairs: the same field codes are run with and without skip, and with pop and push in each order.

// File: rtl/opdec_pkg.sv
package opdec_pkg;
    localparam int WORD_W  = 16;
    localparam int GPR_N   = 8;
    localparam int GIDX_W  = $clog2(GPR_N);
    localparam int OPC_W   = 5;
    localparam int FA_W    = 6;
    localparam int FB_W    = 5;
    localparam int SEL_W   = 4;
    localparam int COST_W  = 3;
    localparam int GPR_BUS = GPR_N * WORD_W;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        LOC_REG  = 2'd0,
        LOC_MEM  = 2'd1,
        LOC_LIT  = 2'd2,
        LOC_NONE = 2'd3
    } loc_kind_e;

    typedef struct packed {
        loc_kind_e        kind;
        logic [SEL_W-1:0] sel;
        word_t            val;
    } loc_t;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_A_REQ,
        FS_A_DAT,
        FS_B_REQ,
        FS_B_DAT,
        FS_FIN
    } fstate_e;

    localparam logic [SEL_W-1:0] SEL_SP = 4'd8;
    localparam logic [SEL_W-1:0] SEL_PC = 4'd9;
    localparam logic [SEL_W-1:0] SEL_EX = 4'd10;

    localparam logic [FB_W-1:0] SPC_CALL = 5'd1;

    // Operand codes that consume one trailing word
    function automatic logic needs_word(input logic [FA_W-1:0] code);
        return (code[5:3] == 3'b010) || (code == 6'h1a) ||
               (code == 6'h1e) || (code == 6'h1f);
    endfunction
endpackage

// File: rtl/opnd_resolve.sv
module opnd_resolve
    import opdec_pkg::*;
#(
    parameter bit IS_SRC = 1'b1
) (
    input  logic [FA_W-1:0]    code,
    input  logic [GPR_BUS-1:0] gpr_i,
    input  word_t              sp_in,
    input  word_t              nw,
    output loc_t               loc,
    output word_t              sp_out
);
    word_t gval;

    always_comb begin
        gval       = gpr_i[code[GIDX_W-1:0]*WORD_W +: WORD_W];
        sp_out     = sp_in;
        loc.kind   = LOC_REG;
        loc.sel    = '0;
        loc.val    = '0;
        if (code[5]) begin
            loc.kind = LOC_LIT;
            loc.val  = {11'b0, code[4:0]} - word_t'(1);
        end else begin
            case (code[4:3])
                2'b00: loc.sel = {1'b0, code[2:0]};
                2'b01: begin
                    loc.kind = LOC_MEM;
                    loc.val  = gval;
                end
                2'b10: begin
                    loc.kind = LOC_MEM;
                    loc.val  = gval + nw;
                end
                default: begin
                    case (code[2:0])
                        3'd0: begin
                            loc.kind = LOC_MEM;
                            if (IS_SRC) begin
                                loc.val = sp_in;
                                sp_out  = sp_in + word_t'(1);
                            end else begin
                                loc.val = sp_in - word_t'(1);
                                sp_out  = sp_in - word_t'(1);
                            end
                        end
                        3'd1: begin
                            loc.kind = LOC_MEM;
                            loc.val  = sp_in;
                        end
                        3'd2: begin
                            loc.kind = LOC_MEM;
                            loc.val  = sp_in + nw;
                        end
                        3'd3: loc.sel = SEL_SP;
                        3'd4: loc.sel = SEL_PC;
                        3'd5: loc.sel = SEL_EX;
                        3'd6: begin
                            loc.kind = LOC_MEM;
                            loc.val  = nw;
                        end
                        default: begin
                            loc.kind = LOC_LIT;
                            loc.val  = nw;
                        end
                    endcase
                end
            endcase
        end
    end
endmodule

// File: rtl/spec_table.sv
module spec_table
    import opdec_pkg::*;
(
    input  logic [FB_W-1:0]   code,
    output logic              known,
    output logic [COST_W-1:0] cost
);
    always_comb begin
        known = 1'b1;
        case (code)
            5'd0:    cost = 3'd1;
            5'd1:    cost = 3'd3;
            5'd2:    cost = 3'd1;
            5'd3:    cost = 3'd4;
            5'd4:    cost = 3'd1;
            5'd5:    cost = 3'd1;
            5'd6:    cost = 3'd2;
            5'd7:    cost = 3'd4;
            5'd8:    cost = 3'd4;
            default: begin
                known = 1'b0;
                cost  = 3'd0;
            end
        endcase
    end
endmodule

// File: rtl/fetch_seq.sv
module fetch_seq
    import opdec_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       need_a,
    input  logic       need_b,
    input  word_t      pc_start,
    output logic       busy,
    output logic       done,
    output logic       mem_rd,
    output word_t      mem_addr,
    output logic       cap_a,
    output logic       cap_b,
    output word_t      pc_cur,
    output logic [1:0] nwords
);
    fstate_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= FS_IDLE;
            pc_cur <= '0;
            nwords <= '0;
        end else begin
            case (state)
                FS_IDLE: if (start) begin
                    pc_cur <= pc_start;
                    nwords <= '0;
                    state  <= need_a ? FS_A_REQ : (need_b ? FS_B_REQ : FS_FIN);
                end
                FS_A_REQ: begin
                    pc_cur <= pc_cur + word_t'(1);
                    nwords <= nwords + 2'd1;
                    state  <= FS_A_DAT;
                end
                FS_A_DAT: state <= need_b ? FS_B_REQ : FS_FIN;
                FS_B_REQ: begin
                    pc_cur <= pc_cur + word_t'(1);
                    nwords <= nwords + 2'd1;
                    state  <= FS_B_DAT;
                end
                FS_B_DAT: state <= FS_FIN;
                default:  state <= FS_IDLE;
            endcase
        end
    end

    assign busy     = (state != FS_IDLE);
    assign done     = (state == FS_FIN);
    assign mem_rd   = (state == FS_A_REQ) || (state == FS_B_REQ);
    assign mem_addr = pc_cur;
    assign cap_a    = (state == FS_A_DAT);
    assign cap_b    = (state == FS_B_DAT);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);  // R12
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !mem_rd);  // R12
    AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> pc_cur == $past(pc_cur) + word_t'(1));  // R3
    AST_WORD_LIMIT: assert property (@(posedge clk) disable iff (rst)
        done |-> nwords <= 2'd2);  // R6
endmodule

// File: rtl/operand_decoder.sv
module operand_decoder
    import opdec_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [15:0]         instr_i,
    input  logic                skip_i,
    input  logic [15:0]         pc_i,
    input  logic [15:0]         sp_i,
    input  logic [127:0]        gpr_i,
    output logic                mem_rd_o,
    output logic [15:0]         mem_addr_o,
    input  logic [15:0]         mem_data_i,
    output logic                busy_o,
    output logic                done_o,
    output logic [4:0]          opcode_o,
    output logic                special_o,
    output logic [4:0]          spec_code_o,
    output logic                spec_known_o,
    output logic [2:0]          spec_cost_o,
    output logic [1:0]          a_kind_o,
    output logic [3:0]          a_sel_o,
    output logic [15:0]         a_val_o,
    output logic [1:0]          b_kind_o,
    output logic [3:0]          b_sel_o,
    output logic [15:0]         b_val_o,
    output logic                b_wr_o,
    output logic [15:0]         sp_o,
    output logic [15:0]         pc_o,
    output logic [1:0]          word_cycles_o
);
    word_t        instr_q, sp_q, nw_a_q, nw_b_q, view;
    logic         skip_q;
    logic         busy, done, cap_a, cap_b, need_a, need_b;
    word_t        pc_cur;
    logic [1:0]   nwords;

    logic [OPC_W-1:0] opc;
    logic [FB_W-1:0]  bfld;
    logic [FA_W-1:0]  afld;
    logic             special, is_call, known;
    logic [COST_W-1:0] cost;
    loc_t             loc_a, loc_b_raw, loc_b;
    word_t            sp_a, sp_b, sp_fin;

    // Decode from the live word when idle, from the held word otherwise
    assign view   = busy ? instr_q : instr_i;
    assign need_a = needs_word(view[15:10]);
    assign need_b = (view[4:0] != '0) && needs_word({1'b0, view[9:5]});

    always_ff @(posedge clk) begin
        if (rst) begin
            instr_q <= '0;
            sp_q    <= '0;
            skip_q  <= 1'b0;
            nw_a_q  <= '0;
            nw_b_q  <= '0;
        end else begin
            if (start_i && !busy) begin
                instr_q <= instr_i;
                sp_q    <= sp_i;
                skip_q  <= skip_i;
            end
            if (cap_a) nw_a_q <= mem_data_i;
            if (cap_b) nw_b_q <= mem_data_i;
        end
    end

    fetch_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start_i),
        .need_a   (need_a),
        .need_b   (need_b),
        .pc_start (pc_i),
        .busy     (busy),
        .done     (done),
        .mem_rd   (mem_rd_o),
        .mem_addr (mem_addr_o),
        .cap_a    (cap_a),
        .cap_b    (cap_b),
        .pc_cur   (pc_cur),
        .nwords   (nwords)
    );

    assign opc     = instr_q[4:0];
    assign bfld    = instr_q[9:5];
    assign afld    = instr_q[15:10];
    assign special = (opc == '0);
    assign is_call = special && (bfld == SPC_CALL);

    // Source first: the destination sees the source's stack effect
    opnd_resolve #(.IS_SRC(1'b1)) u_res_a (
        .code   (afld),
        .gpr_i  (gpr_i),
        .sp_in  (sp_q),
        .nw     (nw_a_q),
        .loc    (loc_a),
        .sp_out (sp_a)
    );

    opnd_resolve #(.IS_SRC(1'b0)) u_res_b (
        .code   ({1'b0, bfld}),
        .gpr_i  (gpr_i),
        .sp_in  (sp_a),
        .nw     (nw_b_q),
        .loc    (loc_b_raw),
        .sp_out (sp_b)
    );

    spec_table u_spec (
        .code  (bfld),
        .known (known),
        .cost  (cost)
    );

    always_comb begin
        loc_b  = loc_b_raw;
        sp_fin = sp_b;
        if (special) begin
            sp_fin     = sp_a;
            loc_b.kind = LOC_NONE;
            loc_b.sel  = '0;
            loc_b.val  = '0;
            if (is_call) begin
                sp_fin     = sp_a - word_t'(1);
                loc_b.kind = LOC_MEM;
                loc_b.val  = sp_a - word_t'(1);
            end
        end
    end

    assign busy_o        = busy;
    assign done_o        = done;
    assign opcode_o      = opc;
    assign special_o     = special;
    assign spec_code_o   = bfld;
    assign spec_known_o  = special && known;
    assign spec_cost_o   = special ? cost : '0;
    assign a_kind_o      = loc_a.kind;
    assign a_sel_o       = loc_a.sel;
    assign a_val_o       = loc_a.val;
    assign b_kind_o      = loc_b.kind;
    assign b_sel_o       = loc_b.sel;
    assign b_val_o       = loc_b.val;
    assign b_wr_o        = special ? is_call : (bfld != 5'h1f);
    assign sp_o          = skip_q ? sp_q : sp_fin;
    assign pc_o          = pc_cur;
    assign word_cycles_o = nwords;

    AST_LIT_READONLY: assert property (@(posedge clk) disable iff (rst)
        done && (loc_b.kind == LOC_LIT || loc_b.kind == LOC_NONE) |-> !b_wr_o);  // R10
    AST_CALL_SLOT: assert property (@(posedge clk) disable iff (rst)
        done && is_call && !skip_q |-> loc_b.val == sp_o);  // R9
    AST_SPECIAL_NOFETCH: assert property (@(posedge clk) disable iff (rst)
        cap_b |-> !special);  // R7
endmodule

// File: tb/operand_decoder_test.sv
`timescale 1ns/1ps
module operand_decoder_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic [15:0]  instr_i = '0;
    logic         skip_i = 1'b0;
    logic [15:0]  pc_i = '0;
    logic [15:0]  sp_i = '0;
    logic [127:0] gpr_i;
    logic         mem_rd_o;
    logic [15:0]  mem_addr_o;
    logic [15:0]  mem_data_i = '0;
    logic         busy_o, done_o, special_o, spec_known_o, b_wr_o;
    logic [4:0]   opcode_o, spec_code_o;
    logic [2:0]   spec_cost_o;
    logic [1:0]   a_kind_o, b_kind_o, word_cycles_o;
    logic [3:0]   a_sel_o, b_sel_o;
    logic [15:0]  a_val_o, b_val_o, sp_o, pc_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int lat = 0;

    always #2 clk = ~clk;

    operand_decoder uut (.*);

    function automatic logic [15:0] gval(input int k);
        return 16'h1000 + 16'(k) * 16'h0111;
    endfunction

    function automatic logic [15:0] mword(input logic [15:0] a);
        return a ^ 16'hA5C3;
    endfunction

    function automatic logic [15:0] mk(input logic [5:0] a, input logic [4:0] b, input logic [4:0] op);
        return {a, b, op};
    endfunction

    initial for (int k = 0; k < 8; k++) gpr_i[k*16 +: 16] = gval(k);

    always_ff @(posedge clk) if (mem_rd_o) mem_data_i <= mword(mem_addr_o);

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [15:0] w, input logic sk, input logic [15:0] sp, input logic [15:0] pc);
        @(negedge clk);
        instr_i = w; skip_i = sk; sp_i = sp; pc_i = pc; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        while (!done_o && lat < 20) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic t_reset;
        chk("R13 busy", busy_o, 0);
        chk("R13 done", done_o, 0);
        chk("R13 mem_rd", mem_rd_o, 0);
    endtask

    task automatic t_regs;
        run_op(mk(6'h03, 5'h05, 5'h02), 0, 16'h8000, 16'h0100);
        chk("R1 opcode", opcode_o, 5'h02);
        chk("R1 special", special_o, 0);
        chk("R2 a reg", {a_kind_o, a_sel_o}, {2'd0, 4'd3});
        chk("R2 b reg", {b_kind_o, b_sel_o}, {2'd0, 4'd5});
        chk("R12 latency 0 words", lat, 1);
        chk("R3 pc unchanged", pc_o, 16'h0100);
        chk("R10 b reg writable", b_wr_o, 1);
        run_op(mk(6'h1d, 5'h1b, 5'h03), 0, 16'h8000, 16'h0100);
        chk("R2 a ex", {a_kind_o, a_sel_o}, {2'd0, 4'd10});
        chk("R2 b sp", {b_kind_o, b_sel_o}, {2'd0, 4'd8});
        run_op(mk(6'h1c, 5'h09, 5'h03), 0, 16'h8000, 16'h0100);
        chk("R2 a pc", {a_kind_o, a_sel_o}, {2'd0, 4'd9});
        chk("R2 b [reg1]", {b_kind_o, b_val_o}, {2'd1, gval(1)});
        run_op(mk(6'h0e, 5'h00, 5'h01), 0, 16'h8000, 16'h0100);
        chk("R2 a [reg6]", {a_kind_o, a_val_o}, {2'd1, gval(6)});
    endtask

    task automatic t_next;
        run_op(mk(6'h12, 5'h1e, 5'h02), 0, 16'h4000, 16'h0200);
        chk("R3 a [word+reg2]", {a_kind_o, a_val_o}, {2'd1, gval(2) + mword(16'h0200)});
        chk("R6 b [word] second", {b_kind_o, b_val_o}, {2'd1, mword(16'h0201)});
        chk("R3 pc", pc_o, 16'h0202);
        chk("R3 words", word_cycles_o, 2);
        chk("R12 latency 2 words", lat, 5);
        run_op(mk(6'h1f, 5'h1a, 5'h02), 0, 16'h4000, 16'h0300);
        chk("R3 a literal word", {a_kind_o, a_val_o}, {2'd2, mword(16'h0300)});
        chk("R3 b [sp+word]", {b_kind_o, b_val_o}, {2'd1, 16'h4000 + mword(16'h0301)});
        run_op(mk(6'h1e, 5'h1f, 5'h01), 0, 16'h4000, 16'h0310);
        chk("R3 b literal", {b_kind_o, b_val_o}, {2'd2, mword(16'h0311)});
        chk("R10 literal not writable", b_wr_o, 0);
        run_op(mk(6'h1e, 5'h00, 5'h01), 0, 16'h4000, 16'h0320);
        chk("R12 latency 1 word", lat, 3);
        chk("R3 a-only pc", pc_o, 16'h0321);
    endtask

    task automatic t_lit;
        run_op(mk(6'h20, 5'h00, 5'h01), 0, 16'h4000, 16'h0);
        chk("R4 lit 0x20", {a_kind_o, a_val_o}, {2'd2, 16'hFFFF});
        run_op(mk(6'h21, 5'h00, 5'h01), 0, 16'h4000, 16'h0);
        chk("R4 lit 0x21", a_val_o, 16'h0000);
        run_op(mk(6'h3f, 5'h00, 5'h01), 0, 16'h4000, 16'h0);
        chk("R4 lit 0x3f", {a_kind_o, a_val_o}, {2'd2, 16'd30});
        chk("R12 literal no fetch", lat, 1);
    endtask

    task automatic t_stack;
        run_op(mk(6'h18, 5'h18, 5'h01), 0, 16'h4000, 16'h0);
        chk("R5 pop addr", a_val_o, 16'h4000);
        chk("R6 push after pop", {b_kind_o, b_val_o}, {2'd1, 16'h4000});
        chk("R5 pop+push sp", sp_o, 16'h4000);
        run_op(mk(6'h19, 5'h18, 5'h01), 0, 16'h4000, 16'h0);
        chk("R5 peek", a_val_o, 16'h4000);
        chk("R5 push addr", b_val_o, 16'h3FFF);
        chk("R5 push sp", sp_o, 16'h3FFF);
        run_op(mk(6'h18, 5'h19, 5'h01), 0, 16'h4000, 16'h0);
        chk("R6 peek after pop", b_val_o, 16'h4001);
        chk("R5 pop sp", sp_o, 16'h4001);
        run_op(mk(6'h00, 5'h18, 5'h01), 0, 16'h0000, 16'h0);
        chk("R5 push wrap", {b_val_o, sp_o}, {16'hFFFF, 16'hFFFF});
    endtask

    task automatic t_special;
        logic [2:0] cost_tab [9];
        cost_tab = '{3'd1, 3'd3, 3'd1, 3'd4, 3'd1, 3'd1, 3'd2, 3'd4, 3'd4};
        for (int k = 0; k < 9; k++) begin
            run_op(mk(6'h02, 5'(k), 5'h00), 0, 16'h5000, 16'h0);
            chk("R8 cost", spec_cost_o, cost_tab[k]);
            chk("R7 known", {special_o, spec_known_o, spec_code_o}, {1'b1, 1'b1, 5'(k)});
            if (k != 1) chk("R7 b none", {b_kind_o, b_wr_o}, {2'd3, 1'b0});
        end
        run_op(mk(6'h02, 5'h1f, 5'h00), 0, 16'h5000, 16'h0);
        chk("R7 unknown", {spec_known_o, spec_cost_o}, {1'b0, 3'd0});
        run_op(mk(6'h02, 5'h1e, 5'h00), 0, 16'h5000, 16'h0400);
        chk("R7 no b fetch", {lat[3:0], word_cycles_o, pc_o}, {4'd1, 2'd0, 16'h0400});
        run_op(mk(6'h02, 5'h1e, 5'h04), 0, 16'h5000, 16'h0400);
        chk("R8 non-special cost", spec_cost_o, 0);
    endtask

    task automatic t_call;
        run_op(mk(6'h1f, 5'h01, 5'h00), 0, 16'h5000, 16'h0300);
        chk("R9 target", {a_kind_o, a_val_o}, {2'd2, mword(16'h0300)});
        chk("R9 pc", pc_o, 16'h0301);
        chk("R9 slot", {b_kind_o, b_val_o, b_wr_o}, {2'd1, 16'h4FFF, 1'b1});
        chk("R9 sp", sp_o, 16'h4FFF);
        run_op(mk(6'h18, 5'h01, 5'h00), 0, 16'h5000, 16'h0300);
        chk("R9 slot after pop", {b_val_o, sp_o}, {16'h5000, 16'h5000});
    endtask

    task automatic t_skip;
        run_op(mk(6'h18, 5'h1e, 5'h02), 1, 16'h6000, 16'h0400);
        chk("R11 sp kept", sp_o, 16'h6000);
        chk("R11 pc advanced", pc_o, 16'h0401);
        chk("R11 latency", lat, 3);
        run_op(mk(6'h18, 5'h1e, 5'h02), 0, 16'h6000, 16'h0400);
        chk("R11 unskipped sp", sp_o, 16'h6001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_regs;
        t_next;
        t_lit;
        t_stack;
        t_special;
        t_call;
        t_skip;
        @(negedge clk);
        chk("R12 done pulse ends", done_o, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule